// File: doc/BRIEF.md
# Selective Bus Monitor Message Filter

This block sits behind the word decoder of a serial avionics command/response bus. For every decoded command word it looks up a host-loaded enable table. If the message is selected, it writes the message's data words into a data stack and then a four-word descriptor entry into a command stack. After the last descriptor word it moves both stack pointers forward. If the message is not selected, nothing is written and no pointer moves.

The enable table has one 16-bit word for each combination of terminal address, direction and upper subaddress bit. The four lower subaddress bits pick one bit of that word. There are two stack areas, and a host-driven area select chooses between them. Each area has its own command stack pointer and its own data stack pointer. All stores go out through a single registered write port, one word per cycle, to a shared memory. Both pointers wrap at their stack size and give a one-cycle rollover pulse when they do.

Top module: `selmon_filter`

## Requirements
- R1: The command word carries the terminal address in bits 15:11, the transmit/receive bit in bit 10 and the subaddress in bits 9:5. The enable table word at index {address, T/R, SA bit 4} is used. Its bit numbered by SA bits 3:0 enables the message. The host writes table words through `tbl_we`/`tbl_addr`/`tbl_wdata`.
- R2: A message whose enable bit is 0 causes no memory write at all, neither to the command stack nor to the data stack.
- R3: A message whose enable bit is 0 leaves both stack pointers of both areas unchanged.
- R4: An enabled message writes four consecutive command stack words, starting at the current command pointer, in this order: block status (`msg_status`), time tag (`time_tag`), data block pointer, received command word. Status and time tag are taken in the cycle `msg_done` is high.
- R5: The data words of an enabled message go to consecutive data stack offsets, wrapping at the stack size, starting at the current data pointer. The data block pointer word is that starting offset, zero-extended to 16 bits.
- R6: The area select is taken in the cycle the command is accepted. All writes and pointer moves of that message use that area, even if the select changes later. `cmd_ptr`/`data_ptr` always show the pair of the area that `area_sel` currently selects.
- R7: The memory address is {region, area, offset}. The region bit is 0 for the command stack and 1 for the data stack, and the offset is in words.
- R8: The pointers move in the cycle after the fourth descriptor word appears on the write port. The command pointer moves by 4 and the data pointer by the number of data words received.
- R9: The command pointer wraps modulo `CMD_WORDS` and the data pointer wraps modulo `DATA_WORDS`. `cmd_wrap`/`data_wrap` are high for exactly the one cycle in which the new, wrapped pointer first shows.
- R10: After reset all four pointers are 0, no write is requested and both rollover flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command word strobe |
| cmd_word | input | 16 | Decoded command word |
| data_valid | input | 1 | Data word strobe |
| data_word | input | 16 | Data word of the current message |
| msg_done | input | 1 | Message complete strobe |
| msg_status | input | 16 | Block status word for the completed message |
| time_tag | input | 16 | Current time tag |
| tbl_we | input | 1 | Host enable table write |
| tbl_addr | input | 7 | Host enable table index |
| tbl_wdata | input | 16 | Host enable table word |
| area_sel | input | 1 | Current stack area (0 = A, 1 = B) |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW (8) | Memory write address {region, area, offset} |
| mem_wdata | output | 16 | Memory write data |
| cmd_ptr | output | CPW (4) | Command stack pointer of selected area |
| data_ptr | output | DPW (6) | Data stack pointer of selected area |
| cmd_wrap | output | 1 | Command pointer rollover pulse |
| data_wrap | output | 1 | Data pointer rollover pulse |

## Verification
Commands are sent with table words that separate the three lookup fields. One pair differs only in SA bit 4, one pair only in direction, one pair only in address, and one pair only in the low subaddress bits. A wrong index or bit selection therefore shows up as a write that should not happen, or as a write that is missing. Message lengths include zero data words, which keeps the data pointer still while an entry is still written. Runs of long messages in one area wrap both stacks at different messages, which separates the two rollover flags. Messages in area B, and one whose area select flips in the middle of the message, show whether the area is latched or taken live.

// File: rtl/selmon_pkg.sv
package selmon_pkg;
  localparam int WORD_W   = 16;
  localparam int TBL_AW   = 7;   // {address[4:0], t/r, sa[4]}
  localparam int TBL_SIZE = 1 << TBL_AW;
  localparam int ENTRY_N  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_COLL, ST_SKIP, ST_ENTRY, ST_DONE
  } mon_state_t;

  function automatic logic [TBL_AW-1:0] tbl_index(input logic [WORD_W-1:0] cw);
    return cw[15:9];
  endfunction

  function automatic logic [3:0] bit_index(input logic [WORD_W-1:0] cw);
    return cw[8:5];
  endfunction
endpackage

// File: rtl/selmon_table.sv
module selmon_table #(
  parameter int DEPTH = 128,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/selmon_ptr_pair.sv
module selmon_ptr_pair #(
  parameter int W     = 4,
  parameter int AMT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               adv_area,
  input  logic [AMT_W-1:0]   amt,
  output logic [1:0][W-1:0]  ptrs,
  output logic               wrap
);
  logic [W:0] sum;
  assign sum = {1'b0, ptrs[adv_area]} + {{(W+1-AMT_W){1'b0}}, amt};

  for (genvar g = 0; g < 2; g++) begin : g_area
    logic [W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst)                                p_q <= '0;
      else if (adv && adv_area == 1'(g))      p_q <= sum[W-1:0];
    end
    assign ptrs[g] = p_q;
  end

  always_ff @(posedge clk) begin
    if (rst) wrap <= 1'b0;
    else     wrap <= adv && sum[W];
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptrs));

  // R9
  wrap_only_on_adv_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> $past(adv));
endmodule

// File: rtl/selmon_filter.sv
module selmon_filter
  import selmon_pkg::*;
#(
  parameter int CMD_WORDS  = 16,
  parameter int DATA_WORDS = 64,
  parameter int MAX_DATA   = 32,
  localparam int CPW = $clog2(CMD_WORDS),
  localparam int DPW = $clog2(DATA_WORDS),
  localparam int DCW = $clog2(MAX_DATA + 1),
  localparam int OW  = (CPW > DPW) ? CPW : DPW,
  localparam int AW  = OW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  input  logic              data_valid,
  input  logic [15:0]       data_word,
  input  logic              msg_done,
  input  logic [15:0]       msg_status,
  input  logic [15:0]       time_tag,
  input  logic              tbl_we,
  input  logic [6:0]        tbl_addr,
  input  logic [15:0]       tbl_wdata,
  input  logic              area_sel,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [CPW-1:0]    cmd_ptr,
  output logic [DPW-1:0]    data_ptr,
  output logic              cmd_wrap,
  output logic              data_wrap
);
  mon_state_t           st;
  logic [WORD_W-1:0]    cmd_r, stat_r, tt_r, tbl_q, entry_word;
  logic                 area_r, en_bit, adv, take_cmd;
  logic [DPW-1:0]       dstart;
  logic [DCW-1:0]       dcnt;
  logic [1:0]           k;
  logic [1:0][CPW-1:0]  cptrs;
  logic [1:0][DPW-1:0]  dptrs;

  assign take_cmd = cmd_valid && (st == ST_IDLE);
  assign adv      = (st == ST_DONE);
  assign en_bit   = tbl_q[bit_index(cmd_r)];

  selmon_table #(.DEPTH(TBL_SIZE), .W(WORD_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(take_cmd), .raddr(tbl_index(cmd_word)), .rdata(tbl_q)
  );

  selmon_ptr_pair #(.W(CPW), .AMT_W(3)) u_cptr (
    .clk(clk), .rst(rst), .adv(adv), .adv_area(area_r), .amt(3'(ENTRY_N)),
    .ptrs(cptrs), .wrap(cmd_wrap)
  );

  selmon_ptr_pair #(.W(DPW), .AMT_W(DCW)) u_dptr (
    .clk(clk), .rst(rst), .adv(adv), .adv_area(area_r), .amt(dcnt),
    .ptrs(dptrs), .wrap(data_wrap)
  );

  assign cmd_ptr  = cptrs[area_sel];
  assign data_ptr = dptrs[area_sel];

  always_comb begin
    case (k)
      2'd0:    entry_word = stat_r;
      2'd1:    entry_word = tt_r;
      2'd2:    entry_word = 16'(dstart);
      default: entry_word = cmd_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      k         <= '0;
      dcnt      <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: if (take_cmd) begin
          cmd_r  <= cmd_word;
          area_r <= area_sel;
          st     <= ST_LOOK;
        end
        ST_LOOK: begin
          dcnt   <= '0;
          dstart <= dptrs[area_r];
          st     <= en_bit ? ST_COLL : ST_SKIP;
        end
        ST_COLL: begin
          if (msg_done) begin
            stat_r <= msg_status;
            tt_r   <= time_tag;
            k      <= '0;
            st     <= ST_ENTRY;
          end else if (data_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= {1'b1, area_r, OW'(dstart + DPW'(dcnt))};
            mem_wdata <= data_word;
            dcnt      <= dcnt + 1'b1;
          end
        end
        ST_SKIP: if (msg_done) st <= ST_IDLE;
        ST_ENTRY: begin
          mem_we    <= 1'b1;
          mem_addr  <= {1'b0, area_r, OW'(cptrs[area_r] + CPW'(k))};
          mem_wdata <= entry_word;
          k         <= k + 2'd1;
          if (k == 2'd3) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  skip_is_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |=> !mem_we);

  // R4
  entry_words_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_addr[AW-1] && $past(mem_we) && !$past(mem_addr[AW-1]))
      |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R5
  data_words_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr[AW-1] && $past(mem_we) && $past(mem_addr[AW-1]))
      |-> (mem_addr[DPW-1:0] == $past(mem_addr[DPW-1:0]) + 1'b1));

  // R8
  ptr_moves_after_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (cptrs != $past(cptrs)) |-> ($past(st) == ST_DONE));
endmodule

// File: tb/tb_selmon_filter.sv
module tb_selmon_filter;
  localparam int CW = 16, DW = 64;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, data_valid = 0, msg_done = 0, tbl_we = 0, area_sel = 0;
  logic [15:0] cmd_word = 0, data_word = 0, msg_status = 0, time_tag = 0, tbl_wdata = 0;
  logic [6:0]  tbl_addr = 0;
  logic        mem_we, cmd_wrap, data_wrap;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [3:0]  cmd_ptr;
  logic [5:0]  data_ptr;

  selmon_filter dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit run = 0, finished = 0;
  logic [15:0] m_tbl [128];
  int m_cp [2], m_dp [2];
  bit exp_cw = 0, exp_dw = 0;
  int qa[$], qd[$];
  string qt[$];
  int wcount = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) if (run) begin
    if (mem_we) begin
      if (qa.size() == 0) chk(0, "R2 unexpected write addr", int'(mem_addr), -1);
      else begin
        int ea, ed; string t;
        ea = qa.pop_front(); ed = qd.pop_front(); t = qt.pop_front();
        chk(int'(mem_addr) == ea, {t, " R7 write address"}, int'(mem_addr), ea);
        chk(int'(mem_wdata) == ed, {t, " write data"}, int'(mem_wdata), ed);
      end
    end
    chk(int'(cmd_ptr) == m_cp[area_sel], "R3 R6 R8 command pointer", int'(cmd_ptr), m_cp[area_sel]);
    chk(int'(data_ptr) == m_dp[area_sel], "R3 R6 R8 data pointer", int'(data_ptr), m_dp[area_sel]);
    chk(cmd_wrap == exp_cw, "R9 command rollover", int'(cmd_wrap), int'(exp_cw));
    chk(data_wrap == exp_dw, "R9 data rollover", int'(data_wrap), int'(exp_dw));
  end

  task automatic load_tbl(int idx, logic [15:0] v);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = 7'(idx); tbl_wdata = v; m_tbl[idx] = v;
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  function automatic logic [15:0] mk(int rta, int tr, int sa, int wc);
    return {5'(rta), 1'(tr), 5'(sa), 5'(wc)};
  endfunction

  // R1 R4 R5 R6: send one message; flip area_sel mid-message when sw is set
  task automatic send(logic [15:0] cw, int n, bit sw, string tag);
    int a, start, idx; bit en; logic [15:0] st, tt;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_word = cw; a = area_sel;
    @(posedge clk); #1;
    cmd_valid = 0;
    idx = int'(cw[15:9]);
    en = m_tbl[idx][cw[8:5]];
    start = m_dp[a];
    if (sw) area_sel = ~area_sel;
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      data_valid = 1; data_word = 16'(16'hD000 + wcount); wcount++;
      if (en) begin qa.push_back(128 + a*64 + (start + i) % DW); qd.push_back(int'(data_word)); qt.push_back({tag, " R5"}); end
      @(posedge clk); #1;
    end
    data_valid = 0;
    st = 16'(16'h5A00 + wcount); tt = 16'(16'h7100 + 3*wcount);
    msg_done = 1; msg_status = st; time_tag = tt;
    @(posedge clk); #1;
    msg_done = 0;
    if (en) begin
      qa.push_back(a*64 + m_cp[a]);     qd.push_back(int'(st));    qt.push_back({tag, " R4 status"});
      qa.push_back(a*64 + m_cp[a] + 1); qd.push_back(int'(tt));    qt.push_back({tag, " R4 time tag"});
      qa.push_back(a*64 + m_cp[a] + 2); qd.push_back(start);       qt.push_back({tag, " R5 block pointer"});
      qa.push_back(a*64 + m_cp[a] + 3); qd.push_back(int'(cw));    qt.push_back({tag, " R4 command"});
    end
    repeat (5) @(posedge clk);
    #1;
    if (en) begin
      exp_cw = (m_cp[a] + 4) >= CW;
      exp_dw = (m_dp[a] + n) >= DW;
      m_cp[a] = (m_cp[a] + 4) % CW;
      m_dp[a] = (m_dp[a] + n) % DW;
    end
    @(posedge clk); #1;
    exp_cw = 0; exp_dw = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    m_cp[0] = 0; m_cp[1] = 0; m_dp[0] = 0; m_dp[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R10 reset state, both areas
    chk(mem_we == 0, "R10 write idle", int'(mem_we), 0);
    chk(cmd_ptr == 0 && data_ptr == 0, "R10 area A pointers", int'({cmd_ptr, data_ptr}), 0);
    chk(cmd_wrap == 0 && data_wrap == 0, "R10 rollover flags", int'({cmd_wrap, data_wrap}), 0);
    area_sel = 1; #1;
    chk(cmd_ptr == 0 && data_ptr == 0, "R10 area B pointers", int'({cmd_ptr, data_ptr}), 0);
    area_sel = 0;
    run = 1;
    for (int i = 0; i < 128; i++) load_tbl(i, 16'h0000);
    load_tbl(5*4 + 0 + 0, 16'h0008);   // addr 5, receive, SA4=0: SA3 on
    load_tbl(5*4 + 2 + 0, 16'h0008);   // addr 5, transmit, SA4=0: SA3 on
    load_tbl(5*4 + 0 + 1, 16'h0004);   // addr 5, receive, SA4=1: SA18 on
    load_tbl(9*4 + 0 + 0, 16'hFFFF);   // addr 9, receive, SA4=0: all on

    send(mk(5, 0, 3, 3),  3, 0, "R1 enabled rx sa3");
    send(mk(5, 0, 2, 4),  4, 0, "R2 R3 disabled sa2");
    send(mk(5, 0, 19, 2), 2, 0, "R1 R2 disabled sa19");
    send(mk(5, 0, 18, 1), 1, 0, "R1 enabled sa18");
    send(mk(5, 1, 3, 0),  0, 0, "R1 enabled tx no data");
    send(mk(6, 0, 3, 2),  2, 0, "R1 R3 disabled other address");
    area_sel = 1;
    send(mk(9, 0, 7, 5),  5, 0, "R6 area B");
    send(mk(9, 0, 1, 2),  2, 1, "R6 area latched");
    area_sel = 0;
    for (int i = 0; i < 4; i++) send(mk(9, 0, i, 20), 20, 0, "R9 area A wrap run");
    area_sel = 1;
    send(mk(9, 0, 4, 0), 32, 0, "R9 area B long");
    send(mk(9, 0, 5, 0), 32, 0, "R9 area B wrap");
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(qa.size() == 0, "R4 all expected writes seen", qa.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule